// File: doc/BRIEF.md
# Block Address Translation Unit

This unit maps an effective address onto a real address through a small set of large, fixed-size translation windows. It checks all windows at once. There are two separate banks of window pairs: one bank serves instruction fetches and the other serves loads and stores. Each pair has two words:

- **Upper word:** the effective block base, a block-length mask, and one enable bit each for supervisor and user mode.
- **Lower word:** the real block base and a two-bit protection code.

A lookup reports whether a window hit and which entry it used. It also reports the merged real page address, the read/write/execute rights of the entry, and whether the current access kind is allowed. A miss reports no hit, so the surrounding logic can fall back to segment and page translation. A hit that lacks the needed rights is reported as a hit that is not granted, so the caller raises a protection fault and not a miss.

A small state machine sequences each lookup through three states:

- **ST_IDLE:** waiting for a request, with `lk_ready` high.
- **ST_COMPARE:** the captured address is compared against the selected bank, and the result is registered.
- **ST_RESULT:** the registered result is presented for one cycle with `rs_valid` high.

The state machine has three transitions:

- **accept** (ST_IDLE to ST_COMPARE) fires when `lk_valid` is high in ST_IDLE.
- **resolve** (ST_COMPARE to ST_RESULT) fires unconditionally.
- **retire** (ST_RESULT to ST_IDLE) fires unconditionally.

A separate write port loads any word of any pair in one cycle.

Top module: `bat_xlate_unit`

## Requirements
- R1: After reset `lk_ready` is 1, `rs_valid` is 0, and every stored word is zero, so every lookup misses until entries are written.
- R2: A request is taken when `lk_valid` and `lk_ready` are both 1 at a clock edge. `lk_ready` is then 0 for two cycles. `rs_valid` is 1 for exactly the one cycle that begins at the second edge after acceptance. `lk_valid` is ignored while `lk_ready` is 0 and produces no result.
- R3: An entry's address matches when EA[31:28] equals upper[31:28] and (EA[27:17] AND NOT M) equals upper[27:17]. M is the 11-bit mask held in upper[12:2] and aligned to address bits 27:17.
- R4: A matching entry counts only if it is enabled for the current mode. Upper bit 1 enables supervisor mode (`lk_user`=0) and upper bit 0 enables user mode (`lk_user`=1).
- R5: The protection code is lower[1:0]. Code 0 gives no rights, code 2 gives read, write and execute, and codes 1 and 3 give read and execute. `rs_perm` is {read, write, execute} from bit 2 down to bit 0.
- R6: On a hit, `rs_raddr` = {lower[31:28], (EA[27:17] AND M) OR lower[27:17], EA[16:12], twelve zero bits}.
- R7: `lk_kind` 2'b10 (fetch) searches the instruction bank. Codes 2'b00 (load) and 2'b01 (store) search the data bank, and 2'b11 behaves as a load. For writes, `wr_side`=1 selects the instruction bank.
- R8: When several enabled entries match, the lowest index wins, and `rs_index` gives that index.
- R9: `rs_granted` is 1 only on a hit whose rights include read for a load, write for a store, or execute for a fetch. A hit without the needed right keeps `rs_hit`=1 with `rs_granted`=0.
- R10: On a miss, `rs_hit`, `rs_granted`, `rs_raddr`, `rs_perm` and `rs_index` are all zero.
- R11: A write stores `wr_data` into pair `wr_idx` (`wr_half`=1 for the upper word, 0 for the lower) at the clock edge. A write at the accept edge is seen by that lookup. A write at the resolve edge is not seen by that lookup, but is seen by the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one stored word |
| wr_side | input | 1 | 1 = instruction bank, 0 = data bank |
| wr_idx | input | 2 | Pair index (log2 of PAIRS) |
| wr_half | input | 1 | 1 = upper word, 0 = lower word |
| wr_data | input | 32 | Word to store |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Unit can take a request |
| lk_ea | input | 32 | Effective address |
| lk_kind | input | 2 | 00 load, 01 store, 10 fetch |
| lk_user | input | 1 | 1 = user mode, 0 = supervisor |
| rs_valid | output | 1 | Result present this cycle |
| rs_hit | output | 1 | An enabled entry matched |
| rs_granted | output | 1 | Access kind permitted |
| rs_raddr | output | 32 | Real page address |
| rs_perm | output | 3 | {read, write, execute} |
| rs_index | output | 2 | Winning entry |

## Verification
Two events can coincide: a register write and a lookup can land on the same clock edge. The bench provokes this in two ways. First, it drives a write to the entry under test in the very cycle the request is accepted. Second, it drives such a write in the compare cycle. Each expectation is taken from a shadow copy of the stored words at the moment the requirement says the lookup samples them: after a write at the accept edge, and before a write at the resolve edge. A follow-up lookup then confirms that the late write did land.

// File: rtl/bat_pkg.sv
package bat_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned PAGE_LSB = 12;
    localparam int unsigned BLEN_W   = 11;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_ALT   = 2'b11
    } acc_kind_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } perm_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COMPARE = 2'd1,
        ST_RESULT  = 2'd2
    } xl_state_e;

    function automatic perm_t pp_to_perm(input logic [1:0] pp);
        perm_t p;
        unique case (pp)
            2'b00:   p = '{rd: 1'b0, wr: 1'b0, ex: 1'b0};
            2'b10:   p = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
            default: p = '{rd: 1'b1, wr: 1'b0, ex: 1'b1};
        endcase
        return p;
    endfunction

    function automatic logic rights_ok(input perm_t p, input acc_kind_e k);
        logic ok;
        unique case (k)
            ACC_STORE: ok = p.wr;
            ACC_FETCH: ok = p.ex;
            default:   ok = p.rd;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/bat_store.sv
module bat_store
    import bat_pkg::*;
#(
    parameter int unsigned PAIRS = 4,
    localparam int unsigned IW = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_side,
    input  logic [IW-1:0]     wr_idx,
    input  logic              wr_half,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] ins_up [PAIRS],
    output logic [WORD_W-1:0] ins_lo [PAIRS],
    output logic [WORD_W-1:0] dat_up [PAIRS],
    output logic [WORD_W-1:0] dat_lo [PAIRS]
);

    for (genvar e = 0; e < PAIRS; e++) begin : g_pair
        logic              sel;
        logic [WORD_W-1:0] r_iu, r_il, r_du, r_dl;

        assign sel = wr_en && (wr_idx == IW'(e));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r_iu <= '0;
                r_il <= '0;
                r_du <= '0;
                r_dl <= '0;
            end else if (sel) begin
                unique case ({wr_side, wr_half})
                    2'b11:   r_iu <= wr_data;
                    2'b10:   r_il <= wr_data;
                    2'b01:   r_du <= wr_data;
                    default: r_dl <= wr_data;
                endcase
            end
        end

        assign ins_up[e] = r_iu;
        assign ins_lo[e] = r_il;
        assign dat_up[e] = r_du;
        assign dat_lo[e] = r_dl;

        // R11: an upper-word write to the instruction bank lands at the edge
        p_ins_upper_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_side && wr_half && wr_idx == IW'(e)) |=> (ins_up[e] == $past(wr_data)));

        // R11: a lower-word write to the data bank lands at the edge
        p_dat_lower_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_side && !wr_half && wr_idx == IW'(e)) |=> (dat_lo[e] == $past(wr_data)));

        // R11: with no write to this pair, its data upper word holds
        p_pair_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_idx == IW'(e)) |=> $stable(dat_up[e]));
    end

endmodule

// File: rtl/bat_entry_eval.sv
module bat_entry_eval
    import bat_pkg::*;
(
    input  logic [WORD_W-1:0] ea,
    input  logic              user,
    input  logic [WORD_W-1:0] up,
    input  logic [WORD_W-1:0] lo,
    output logic              take,
    output logic [WORD_W-1:0] ra,
    output perm_t             perm
);

    logic [BLEN_W-1:0] blen;
    logic              seg_eq;
    logic              blk_eq;
    logic              mode_ok;

    always_comb begin
        blen    = up[12:2];
        seg_eq  = (ea[31:28] == up[31:28]);
        blk_eq  = ((ea[27:17] & ~blen) == up[27:17]);
        mode_ok = user ? up[0] : up[1];
        take    = seg_eq && blk_eq && mode_ok;
        ra      = {lo[31:28], (ea[27:17] & blen) | lo[27:17], ea[16:12], {PAGE_LSB{1'b0}}};
        perm    = pp_to_perm(lo[1:0]);
    end

endmodule

// File: rtl/bat_first_hit.sv
module bat_first_hit #(
    parameter int unsigned PAIRS = 4,
    localparam int unsigned IW = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
    input  logic [PAIRS-1:0] req,
    output logic             found,
    output logic [IW-1:0]    idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = PAIRS - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/bat_xlate_unit.sv
module bat_xlate_unit
    import bat_pkg::*;
#(
    parameter int unsigned PAIRS = 4,
    localparam int unsigned IW = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_side,
    input  logic [IW-1:0]     wr_idx,
    input  logic              wr_half,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              lk_valid,
    output logic              lk_ready,
    input  logic [WORD_W-1:0] lk_ea,
    input  logic [1:0]        lk_kind,
    input  logic              lk_user,
    output logic              rs_valid,
    output logic              rs_hit,
    output logic              rs_granted,
    output logic [WORD_W-1:0] rs_raddr,
    output logic [2:0]        rs_perm,
    output logic [IW-1:0]     rs_index
);

    xl_state_e state, nxt;

    logic [WORD_W-1:0] q_ea;
    acc_kind_e         q_kind;
    logic              q_user;

    logic [WORD_W-1:0] ins_up [PAIRS];
    logic [WORD_W-1:0] ins_lo [PAIRS];
    logic [WORD_W-1:0] dat_up [PAIRS];
    logic [WORD_W-1:0] dat_lo [PAIRS];

    logic [WORD_W-1:0] ra_v   [PAIRS];
    perm_t             perm_v [PAIRS];
    logic [PAIRS-1:0]  take_v;
    logic              found;
    logic [IW-1:0]     win;
    logic              is_fetch;

    logic              r_hit, r_grant;
    logic [WORD_W-1:0] r_raddr;
    perm_t             r_perm;
    logic [IW-1:0]     r_idx;

    bat_store #(.PAIRS(PAIRS)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_side(wr_side),
        .wr_idx (wr_idx),
        .wr_half(wr_half),
        .wr_data(wr_data),
        .ins_up (ins_up),
        .ins_lo (ins_lo),
        .dat_up (dat_up),
        .dat_lo (dat_lo)
    );

    assign is_fetch = (q_kind == ACC_FETCH);

    for (genvar e = 0; e < PAIRS; e++) begin : g_eval
        bat_entry_eval u_eval (
            .ea  (q_ea),
            .user(q_user),
            .up  (is_fetch ? ins_up[e] : dat_up[e]),
            .lo  (is_fetch ? ins_lo[e] : dat_lo[e]),
            .take(take_v[e]),
            .ra  (ra_v[e]),
            .perm(perm_v[e])
        );
    end

    bat_first_hit #(.PAIRS(PAIRS)) u_pick (
        .req  (take_v),
        .found(found),
        .idx  (win)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions: accept, resolve, retire
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (lk_valid) nxt = ST_COMPARE;
            ST_COMPARE: nxt = ST_RESULT;
            ST_RESULT:  nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // request capture on accept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_ea   <= '0;
            q_kind <= ACC_LOAD;
            q_user <= 1'b0;
        end else if (state == ST_IDLE && lk_valid) begin
            q_ea   <= lk_ea;
            q_kind <= acc_kind_e'(lk_kind);
            q_user <= lk_user;
        end
    end

    // result capture on resolve
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_hit   <= 1'b0;
            r_grant <= 1'b0;
            r_raddr <= '0;
            r_perm  <= '0;
            r_idx   <= '0;
        end else if (state == ST_COMPARE) begin
            r_hit <= found;
            if (found) begin
                r_raddr <= ra_v[win];
                r_perm  <= perm_v[win];
                r_grant <= rights_ok(perm_v[win], q_kind);
                r_idx   <= win;
            end else begin
                r_raddr <= '0;
                r_perm  <= '0;
                r_grant <= 1'b0;
                r_idx   <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        lk_ready   = (state == ST_IDLE);
        rs_valid   = (state == ST_RESULT);
        rs_hit     = r_hit;
        rs_granted = r_grant;
        rs_raddr   = r_raddr;
        rs_perm    = r_perm;
        rs_index   = r_idx;
    end

    p_result_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |=> !rs_valid);

    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |=> !lk_ready);

    p_result_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |-> !lk_ready);

    p_grant_needs_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_granted) |-> rs_hit);

    p_no_rights_no_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_perm == 3'b000) |-> !rs_granted);

    p_miss_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && !rs_hit) |-> (rs_raddr == '0 && rs_perm == 3'b000 && rs_index == '0));

    p_page_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |-> (rs_raddr[PAGE_LSB-1:0] == '0));

endmodule

// File: tb/bat_xlate_unit_bench.sv
`timescale 1ns/1ps
module bat_xlate_unit_bench;

    localparam int PAIRS = 4;
    localparam int IW    = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, wr_side = 1'b0, wr_half = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [31:0]   wr_data = '0;
    logic          lk_valid = 1'b0, lk_user = 1'b0;
    logic [31:0]   lk_ea = '0;
    logic [1:0]    lk_kind = 2'b00;
    logic          lk_ready, rs_valid, rs_hit, rs_granted;
    logic [31:0]   rs_raddr;
    logic [2:0]    rs_perm;
    logic [IW-1:0] rs_index;

    always #5 clk = ~clk;

    bat_xlate_unit #(.PAIRS(PAIRS)) u_bat_xlate_unit (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_side(wr_side), .wr_idx(wr_idx), .wr_half(wr_half), .wr_data(wr_data),
        .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_ea(lk_ea), .lk_kind(lk_kind), .lk_user(lk_user),
        .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_granted(rs_granted),
        .rs_raddr(rs_raddr), .rs_perm(rs_perm), .rs_index(rs_index)
    );

    typedef struct packed {
        logic          hit;
        logic          gr;
        logic [31:0]   ra;
        logic [2:0]    pm;
        logic [IW-1:0] ix;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    logic [31:0] sh_iu [PAIRS];
    logic [31:0] sh_il [PAIRS];
    logic [31:0] sh_du [PAIRS];
    logic [31:0] sh_dl [PAIRS];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // reference model written from R3..R10
    function automatic exp_t model(input logic [31:0] ea, input logic [1:0] kind, input logic user);
        exp_t r;
        r = '0;
        for (int i = 0; i < PAIRS; i++) begin
            logic [31:0] u, l;
            logic [10:0] m;
            logic [2:0]  p;
            u = (kind == 2'b10) ? sh_iu[i] : sh_du[i];
            l = (kind == 2'b10) ? sh_il[i] : sh_dl[i];
            m = u[12:2];
            if (!r.hit && ea[31:28] == u[31:28] && ((ea[27:17] & ~m) == u[27:17])
                && (user ? u[0] : u[1])) begin
                r.hit = 1'b1;
                r.ix  = IW'(i);
                r.ra  = {l[31:28], (ea[27:17] & m) | l[27:17], ea[16:12], 12'h000};
                p = (l[1:0] == 2'b00) ? 3'b000 : (l[1:0] == 2'b10) ? 3'b111 : 3'b101;
                r.pm = p;
                r.gr = (kind == 2'b01) ? p[1] : (kind == 2'b10) ? p[0] : p[2];
            end
        end
        return r;
    endfunction

    task automatic shadow_wr(input logic side, input logic [IW-1:0] idx, input logic half, input logic [31:0] d);
        if (side && half)       sh_iu[idx] = d;
        else if (side)          sh_il[idx] = d;
        else if (half)          sh_du[idx] = d;
        else                    sh_dl[idx] = d;
    endtask

    task automatic drive_wr(input logic side, input logic [IW-1:0] idx, input logic half, input logic [31:0] d);
        wr_en = 1'b1; wr_side = side; wr_idx = idx; wr_half = half; wr_data = d;
        shadow_wr(side, idx, half, d);
    endtask

    task automatic put(input logic side, input logic [IW-1:0] idx, input logic half, input logic [31:0] d);
        @(negedge clk);
        drive_wr(side, idx, half, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // mode 0: plain, 1: write at accept edge, 2: write at resolve edge, 3: extra request while busy
    task automatic lookup(input logic [31:0] ea, input logic [1:0] kind, input logic user,
                          input string tag, input int mode,
                          input logic wside, input logic [IW-1:0] widx, input logic whalf,
                          input logic [31:0] wd);
        @(negedge clk);
        while (!lk_ready) @(negedge clk);
        if (mode == 1) drive_wr(wside, widx, whalf, wd);
        exp_q.push_back(model(ea, kind, user));
        tag_q.push_back(tag);
        lk_valid = 1'b1; lk_ea = ea; lk_kind = kind; lk_user = user;
        @(negedge clk);
        lk_valid = 1'b0; wr_en = 1'b0;
        chk(lk_ready == 1'b0, "R2", "ready in compare", 32'(lk_ready), 32'd0);
        chk(rs_valid == 1'b0, "R2", "valid in compare", 32'(rs_valid), 32'd0);
        if (mode == 2) drive_wr(wside, widx, whalf, wd);
        if (mode == 3) begin
            lk_valid = 1'b1; lk_ea = ea ^ 32'h0F00_0000;
        end
        @(negedge clk);
        wr_en = 1'b0; lk_valid = 1'b0;
        chk(rs_valid == 1'b1, "R2", "valid in result", 32'(rs_valid), 32'd1);
        if (mode == 3)
            chk(lk_ready == 1'b0, "R2", "ready in result", 32'(lk_ready), 32'd0);
    endtask

    task automatic look(input logic [31:0] ea, input logic [1:0] kind, input logic user, input string tag);
        lookup(ea, kind, user, tag, 0, 1'b0, '0, 1'b0, 32'h0);
    endtask

    // monitor: pops one expectation per result
    always @(negedge clk) begin
        if (rst_n && rs_valid) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R2 unexpected result: actual hit=%0b expected none", rs_hit);
            end else begin
                exp_t  e;
                string t;
                bit    bad;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                bad = 1'b0;
                n_cmp++;
                if (rs_hit !== e.hit) begin bad = 1'b1; $display("FAIL %s hit: actual %0b expected %0b", t, rs_hit, e.hit); end
                if (rs_granted !== e.gr) begin bad = 1'b1; $display("FAIL %s granted: actual %0b expected %0b", t, rs_granted, e.gr); end
                if (rs_raddr !== e.ra) begin bad = 1'b1; $display("FAIL %s raddr: actual %h expected %h", t, rs_raddr, e.ra); end
                if (rs_perm !== e.pm) begin bad = 1'b1; $display("FAIL %s perm: actual %b expected %b", t, rs_perm, e.pm); end
                if (rs_index !== e.ix) begin bad = 1'b1; $display("FAIL %s index: actual %0d expected %0d", t, rs_index, e.ix); end
                if (bad) n_bad++;
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < PAIRS; i++) begin
            sh_iu[i] = '0; sh_il[i] = '0; sh_du[i] = '0; sh_dl[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(lk_ready == 1'b1, "R1", "ready after reset", 32'(lk_ready), 32'd1);
        chk(rs_valid == 1'b0, "R1", "valid after reset", 32'(rs_valid), 32'd0);
        look(32'h1001_5678, 2'b00, 1'b0, "R1 empty miss");
        look(32'h0000_0000, 2'b10, 1'b1, "R10 empty fetch miss");

        put(1'b0, 2'd0, 1'b1, 32'h1000_0002);
        put(1'b0, 2'd0, 1'b0, 32'h8000_0002);
        put(1'b0, 2'd1, 1'b1, 32'h2000_001F);
        put(1'b0, 2'd1, 1'b0, 32'h4000_0001);
        put(1'b0, 2'd2, 1'b1, 32'h2000_0003);
        put(1'b0, 2'd2, 1'b0, 32'h5000_0002);
        put(1'b1, 2'd3, 1'b1, 32'hF000_1FFF);
        put(1'b1, 2'd3, 1'b0, 32'h3000_0003);
        put(1'b1, 2'd0, 1'b1, 32'h0000_0002);
        put(1'b1, 2'd0, 1'b0, 32'h7000_0000);

        look(32'h1001_5678, 2'b00, 1'b0, "R6 supervisor load");
        look(32'h1001_5678, 2'b01, 1'b0, "R9 supervisor store rwx");
        look(32'h1001_5678, 2'b00, 1'b1, "R4 user disabled");
        look(32'h200A_3123, 2'b01, 1'b1, "R3 masked match store violation R9");
        look(32'h200A_3123, 2'b00, 1'b1, "R9 user load granted");
        look(32'h200A_3123, 2'b11, 1'b1, "R7 code 11 as load");
        look(32'h2000_4000, 2'b00, 1'b0, "R8 lowest index wins");
        look(32'h2010_0000, 2'b00, 1'b0, "R3 unmasked bit differs");
        look(32'hF123_4567, 2'b10, 1'b0, "R7 fetch instruction bank");
        look(32'hF123_4567, 2'b10, 1'b1, "R4 user fetch");
        look(32'hF123_4567, 2'b00, 1'b0, "R7 load data bank miss R10");
        look(32'h0000_1000, 2'b10, 1'b0, "R5 code zero no rights");
        look(32'hF123_4567, 2'b01, 1'b0, "R10 store miss");

        put(1'b0, 2'd1, 1'b1, 32'h2000_001D);
        look(32'h2000_4000, 2'b00, 1'b0, "R8 next enabled entry");
        look(32'h2000_4000, 2'b00, 1'b1, "R4 user-only entry");

        lookup(32'h1001_5678, 2'b00, 1'b0, "R11 write at accept", 1, 1'b0, 2'd0, 1'b0, 32'h9000_0002);
        lookup(32'h1001_5678, 2'b00, 1'b0, "R11 write at resolve", 2, 1'b0, 2'd0, 1'b0, 32'hA000_0002);
        look(32'h1001_5678, 2'b00, 1'b0, "R11 late write visible");
        lookup(32'h1001_5678, 2'b10, 1'b0, "R2 busy request ignored", 3, 1'b0, 2'd0, 1'b0, 32'h0);

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R2", "results outstanding", 32'(exp_q.size()), 32'd0);
        finish_run();
    end

endmodule